// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address onto a real address using two small banks of block-translation entries: one bank for instruction fetches and one for data accesses, each with four entries. Every entry holds an upper word and a lower word. The upper word describes which power-of-two region of the effective space the entry covers and in which privilege states it is usable. The lower word gives the real page the region lands on, its storage attributes (WIMG) and its access permissions. Each block spans 2^(17 + set mask bits) bytes, from 128 KB up to 256 MB, and is aligned to its own size.

The lookup is purely combinational. Each access presents an address, an access type, a store flag, a user-mode flag and the two relocation enables. The unit returns a hit flag, the real address, the four storage attribute bits and a protection-fault flag in the same cycle. The entries are loaded one 32-bit word at a time through a synchronous write port. Bit positions below are numbered with bit 0 as the least significant bit.

Top module: `bat_xlate_unit`

## Requirements
- R1: After reset every entry word is zero, so no access hits until an entry has been written.
- R2: When wr_en is high at a rising clock edge, wr_data is stored in the word picked by wr_side (1 = instruction bank, 0 = data bank), wr_idx and wr_hi (1 = upper word, 0 = lower word). The new contents take effect for lookups from the next cycle on.
- R3: Upper word fields: [31:17] block page index, [12:2] length mask, [1] supervisor-usable, [0] user-usable. Lower word fields: [31:17] real page, [6:3] WIMG, [1:0] PP. All other bits are ignored.
- R4: An entry matches when {ea[31:28], ea[27:17] & ~mask} equals its 15-bit block page index. A mask of 0x003 therefore covers 512 KB.
- R5: On a hit, real_addr[31:17] = real page | {4'b0, ea[27:17] & mask}, and real_addr[16:0] = ea[16:0].
- R6: An entry can hit only if it is usable in the current state, meaning supervisor-usable with user_mode = 0 or user-usable with user_mode = 1. The relocation enable for the access type must also be high: ifetch_reloc for fetches and data_reloc for data accesses.
- R7: A fetch (is_ifetch = 1) searches only the instruction bank. A data access searches only the data bank.
- R8: When several entries of the searched bank would hit, the lowest-numbered one provides the result.
- R9: PP = 00 faults on every access. PP = 01 or 11 faults on stores only. PP = 10 never faults. A fault still reports hit = 1 together with the translated address.
- R10: A fetch is treated as a read, so is_store has no effect when is_ifetch = 1.
- R11: On a miss, hit, real_addr, wimg and prot_fault are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Entry word write strobe |
| wr_side | input | 1 | 1 = instruction bank, 0 = data bank |
| wr_idx | input | 2 | Entry number within the bank |
| wr_hi | input | 1 | 1 = upper word, 0 = lower word |
| wr_data | input | 32 | Word to store |
| ea | input | 32 | Effective address of the access |
| is_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| is_store | input | 1 | Data access is a write |
| user_mode | input | 1 | 1 = user state, 0 = supervisor |
| ifetch_reloc | input | 1 | Translation enabled for fetches |
| data_reloc | input | 1 | Translation enabled for data |
| hit | output | 1 | A usable entry covers ea |
| real_addr | output | 32 | Translated address (0 on miss) |
| wimg | output | 4 | Storage attributes of the hit entry |
| prot_fault | output | 1 | Access denied by PP |

## Verification
The bench goes after blocks at their size limits: an address one byte past a 512 KB block must miss, and a design that applied the mask to the wrong bits would stretch or shrink the block. Overlapping entries check the priority order, because a selector that favoured the highest index, or merged two entries, would return the wrong real page. Privilege and relocation corners check the usability rule: flipping user_mode or clearing the relocation enable for the access type must turn a hit into a miss, and a design that looked at the other bank's enable would still hit. The permission corners drive stores into read-only blocks, fetches with is_store high, and PP = 00 reads. A design that dropped hit on a fault, or faulted on fetches, is caught there. Random traffic aimed inside and around randomly loaded blocks covers the address merge for all mask widths.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int EA_W   = 32;
  localparam int PAGE_W = 15;
  localparam int MASK_W = 11;
  localparam int TOP_W  = PAGE_W - MASK_W;
  localparam int OFF_W  = EA_W - PAGE_W;
  localparam int WIMG_W = 4;

  typedef struct packed {
    logic [PAGE_W-1:0] bepi;
    logic [3:0]        rsv;
    logic [MASK_W-1:0] blen;
    logic              sup_ok;
    logic              usr_ok;
  } bat_up_t;

  typedef struct packed {
    logic [PAGE_W-1:0] rpage;
    logic [9:0]        rsv_a;
    logic [WIMG_W-1:0] wimg;
    logic              rsv_b;
    logic [1:0]        pp;
  } bat_lo_t;

  function automatic logic blk_match(input bat_up_t u, input logic [EA_W-1:0] a);
    logic [PAGE_W-1:0] key;
    key = {a[EA_W-1 -: TOP_W], a[OFF_W +: MASK_W] & ~u.blen};
    return key == u.bepi;
  endfunction

  function automatic logic blk_usable(input bat_up_t u, input logic usr);
    return (u.sup_ok & ~usr) | (u.usr_ok & usr);
  endfunction

  function automatic logic [EA_W-1:0] blk_real(input bat_up_t u, input bat_lo_t l,
                                               input logic [EA_W-1:0] a);
    logic [PAGE_W-1:0] pg;
    pg = l.rpage | {{TOP_W{1'b0}}, a[OFF_W +: MASK_W] & u.blen};
    return {pg, a[OFF_W-1:0]};
  endfunction

  function automatic logic blk_denied(input logic [1:0] pp, input logic store);
    return (pp == 2'b00) | (pp[0] & store);
  endfunction
endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
  import bat_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           wr_side,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic                           wr_hi,
  input  logic [EA_W-1:0]                wr_data,
  output bat_up_t [NUM_PAIRS-1:0]        i_up,
  output bat_lo_t [NUM_PAIRS-1:0]        i_lo,
  output bat_up_t [NUM_PAIRS-1:0]        d_up,
  output bat_lo_t [NUM_PAIRS-1:0]        d_lo
);
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        i_up[g] <= '0;
        i_lo[g] <= '0;
        d_up[g] <= '0;
        d_lo[g] <= '0;
      end else if (sel) begin
        if (wr_side && wr_hi)   i_up[g] <= bat_up_t'(wr_data);
        if (wr_side && !wr_hi)  i_lo[g] <= bat_lo_t'(wr_data);
        if (!wr_side && wr_hi)  d_up[g] <= bat_up_t'(wr_data);
        if (!wr_side && !wr_hi) d_lo[g] <= bat_lo_t'(wr_data);
      end
    end
  end
endmodule

// File: rtl/bat_entry_cmp.sv
module bat_entry_cmp
  import bat_pkg::*;
(
  input  bat_up_t         up,
  input  logic [EA_W-1:0] ea,
  input  logic            user_mode,
  input  logic            reloc_on,
  output logic            hit
);
  logic addr_ok;
  logic state_ok;
  assign addr_ok  = blk_match(up, ea);
  assign state_ok = blk_usable(up, user_mode);
  assign hit      = reloc_on & state_ok & addr_ok;
endmodule

// File: rtl/bat_prio_sel.sv
module bat_prio_sel #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) grant = N'(1) << i;
    end
  end
  assign any = |req;
endmodule

// File: rtl/bat_xlate_unit.sv
module bat_xlate_unit
  import bat_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_side,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_hi,
  input  logic [EA_W-1:0]   wr_data,
  input  logic [EA_W-1:0]   ea,
  input  logic              is_ifetch,
  input  logic              is_store,
  input  logic              user_mode,
  input  logic              ifetch_reloc,
  input  logic              data_reloc,
  output logic              hit,
  output logic [EA_W-1:0]   real_addr,
  output logic [WIMG_W-1:0] wimg,
  output logic              prot_fault
);
  bat_up_t [NUM_PAIRS-1:0] i_up, d_up, act_up;
  bat_lo_t [NUM_PAIRS-1:0] i_lo, d_lo, act_lo;
  logic [NUM_PAIRS-1:0]    ent_hit;
  logic [NUM_PAIRS-1:0]    grant;
  logic                    any_hit;
  logic                    reloc_on;
  logic                    eff_store;
  bat_up_t                 sel_up;
  bat_lo_t                 sel_lo;
  logic [1:0]              sel_pp;

  bat_regfile #(.NUM_PAIRS(NUM_PAIRS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side),
    .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_data(wr_data),
    .i_up(i_up), .i_lo(i_lo), .d_up(d_up), .d_lo(d_lo)
  );

  assign act_up    = is_ifetch ? i_up : d_up;
  assign act_lo    = is_ifetch ? i_lo : d_lo;
  assign reloc_on  = is_ifetch ? ifetch_reloc : data_reloc;
  assign eff_store = is_store & ~is_ifetch;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_cmp
    bat_entry_cmp u_cmp (
      .up(act_up[g]), .ea(ea), .user_mode(user_mode),
      .reloc_on(reloc_on), .hit(ent_hit[g])
    );
  end

  bat_prio_sel #(.N(NUM_PAIRS)) u_prio (
    .req(ent_hit), .grant(grant), .any(any_hit)
  );

  always_comb begin
    sel_up = '0;
    sel_lo = '0;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      if (grant[i]) begin
        sel_up = sel_up | act_up[i];
        sel_lo = sel_lo | act_lo[i];
      end
    end
  end

  assign sel_pp     = sel_lo.pp;
  assign hit        = any_hit;
  assign real_addr  = any_hit ? blk_real(sel_up, sel_lo, ea) : '0;
  assign wimg       = any_hit ? sel_lo.wimg : '0;
  assign prot_fault = any_hit & blk_denied(sel_pp, eff_store);
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk #(
  parameter int NUM_PAIRS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [31:0]          ea,
  input logic                 is_ifetch,
  input logic                 ifetch_reloc,
  input logic                 data_reloc,
  input logic                 hit,
  input logic [31:0]          real_addr,
  input logic [3:0]           wimg,
  input logic                 prot_fault,
  input logic [NUM_PAIRS-1:0] ent_hit,
  input logic [NUM_PAIRS-1:0] grant,
  input logic [1:0]           sel_pp
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R8
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (((grant & ~ent_hit) == '0) && (((grant - 1'b1) & ent_hit) == '0))); // R8
  AST_FAULT_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> hit); // R9
  AST_RW_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && sel_pp == 2'b10) |-> !prot_fault); // R9
  AST_FETCH_NO_STORE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && is_ifetch && sel_pp != 2'b00) |-> !prot_fault); // R10
  AST_RELOC_OFF_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ifetch ? !ifetch_reloc : !data_reloc) |-> !hit); // R6
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (real_addr[16:0] == ea[16:0])); // R5
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (real_addr == '0 && wimg == '0 && !prot_fault)); // R11
endmodule

bind bat_xlate_unit bat_xlate_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ea(ea), .is_ifetch(is_ifetch),
  .ifetch_reloc(ifetch_reloc), .data_reloc(data_reloc), .hit(hit),
  .real_addr(real_addr), .wimg(wimg), .prot_fault(prot_fault),
  .ent_hit(ent_hit), .grant(grant), .sel_pp(sel_pp)
);

// File: tb/tb_bat_xlate_unit.sv
module tb_bat_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_side = 1'b0, wr_hi = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0, ea = '0;
  logic        is_ifetch = 1'b0, is_store = 1'b0, user_mode = 1'b0;
  logic        ifetch_reloc = 1'b0, data_reloc = 1'b0;
  logic        hit, prot_fault;
  logic [31:0] real_addr;
  logic [3:0]  wimg;

  int checks = 0;
  int failures = 0;
  logic [31:0] m_up [2][4];
  logic [31:0] m_lo [2][4];

  always #4 clk = ~clk;

  bat_xlate_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx),
    .wr_hi(wr_hi), .wr_data(wr_data), .ea(ea), .is_ifetch(is_ifetch),
    .is_store(is_store), .user_mode(user_mode), .ifetch_reloc(ifetch_reloc),
    .data_reloc(data_reloc), .hit(hit), .real_addr(real_addr), .wimg(wimg),
    .prot_fault(prot_fault)
  );

  // Reference: mask expanded to a 32-bit window, compare in place.
  function automatic logic [38:0] model(input logic [31:0] a, input logic f,
                                        input logic st, input logic u,
                                        input logic ir, input logic dr);
    logic [31:0] up, lo, win;
    logic [38:0] r;
    int s;
    r = '0;
    s = f ? 1 : 0;
    if (!(f ? ir : dr)) return r;
    for (int k = 3; k >= 0; k--) begin
      up  = m_up[s][k];
      lo  = m_lo[s][k];
      win = (up & 32'h0000_1FFC) << 15;
      if ((((a & ~win) ^ up) & 32'hFFFE_0000) == 0 &&
          ((u && up[0]) || (!u && up[1]))) begin
        r[38] = 1'b1;
        r[37:6] = (lo & 32'hFFFE_0000) | (a & win) | (a & 32'h0001_FFFF);
        r[5:2] = lo[6:3];
        r[1] = (lo[1:0] == 2'b00) || (lo[0] && st && !f);
        r[0] = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic wreg(input logic side, input int idx, input logic hi, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_side = side; wr_idx = 2'(idx); wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (hi) m_up[side ? 1 : 0][idx] = d; else m_lo[side ? 1 : 0][idx] = d;
  endtask

  task automatic access(input string tag, input logic [31:0] a, input logic f,
                        input logic st, input logic u, input logic ir, input logic dr);
    logic [38:0] e, g;
    @(negedge clk);
    ea = a; is_ifetch = f; is_store = st; user_mode = u;
    ifetch_reloc = ir; data_reloc = dr;
    #2;
    e = model(a, f, st, u, ir, dr);
    g = {hit, real_addr, wimg, prot_fault, 1'b0};
    checks++;
    if (g !== e) begin
      failures++;
      $display("FAIL %s ea=%h got hit=%b ra=%h wimg=%h flt=%b exp hit=%b ra=%h wimg=%h flt=%b",
               tag, a, g[38], g[37:6], g[5:2], g[1], e[38], e[37:6], e[5:2], e[1]);
    end
  endtask

  task automatic expect_hit(input string tag, input logic eh, input logic [31:0] era);
    checks++;
    if (hit !== eh || (eh && real_addr !== era)) begin
      failures++;
      $display("FAIL %s hit=%b ra=%h exp hit=%b ra=%h", tag, hit, real_addr, eh, era);
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(20240607);
    for (int s = 0; s < 2; s++) for (int k = 0; k < 4; k++) begin
      m_up[s][k] = '0; m_lo[s][k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing hits after reset
    access("R1 reset data", 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    access("R1 reset fetch", 32'h0000_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    expect_hit("R1 reset", 1'b0, 32'h0);
    // R2 R3: data entry 0, page 0x1000_0000, mask 0x003, supervisor, rpage 0x8000_0000, WIMG 0101, PP 10
    wreg(1'b0, 0, 1'b1, 32'h1000_0000 | (32'h003 << 2) | 32'h2);
    wreg(1'b0, 0, 1'b0, 32'h8000_0000 | (32'h5 << 3) | 32'h2);
    access("R2 loaded", 32'h1007_1234, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    expect_hit("R5 merge 512KB", 1'b1, 32'h8007_1234);
    access("R4 past block end", 32'h1008_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_hit("R4 past block end", 1'b0, 32'h0);
    access("R4 last byte", 32'h1007_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    access("R6 user state", 32'h1000_0010, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    expect_hit("R6 user miss", 1'b0, 32'h0);
    access("R6 data reloc off", 32'h1000_0010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_hit("R6 reloc off", 1'b0, 32'h0);
    access("R7 fetch other bank", 32'h1000_0010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_hit("R7 fetch miss", 1'b0, 32'h0);
    // R8: data entry 2 overlaps, both states, different page
    wreg(1'b0, 2, 1'b1, 32'h1000_0000 | 32'h3);
    wreg(1'b0, 2, 1'b0, 32'h4000_0000 | (32'hA << 3) | 32'h1);
    access("R8 lowest wins", 32'h1000_0040, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_hit("R8 lowest wins", 1'b1, 32'h8000_0040);
    access("R8 user picks 2", 32'h1000_0040, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    expect_hit("R8 entry 2 user", 1'b1, 32'h4000_0040);
    // R9: read-only store faults, PP 00 read faults
    access("R9 ro store", 32'h1000_0040, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    access("R9 ro load", 32'h1000_0040, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    wreg(1'b0, 2, 1'b0, 32'h4000_0000);
    access("R9 pp00 load", 32'h1000_0040, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    access("R9 rw store", 32'h1000_0040, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    // R10: fetch from read-only instruction entry with is_store high; 256 MB block
    wreg(1'b1, 1, 1'b1, 32'h2000_0000 | (32'h7FF << 2) | 32'h3);
    wreg(1'b1, 1, 1'b0, 32'hC000_0000 | (32'hF << 3) | 32'h3);
    access("R10 fetch store ignored", 32'h2ABC_DEF0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_hit("R5 256MB", 1'b1, 32'hCABC_DEF0);
    access("R6 fetch reloc off", 32'h2ABC_DEF0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    access("R11 miss quiet", 32'h7000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    // R3: reserved bits ignored
    wreg(1'b0, 3, 1'b1, 32'h5000_0000 | 32'h0001_E000 | 32'h2);
    wreg(1'b0, 3, 1'b0, 32'h6000_0000 | 32'h0001_FF84 | 32'h2);
    access("R3 reserved bits", 32'h5001_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    // Random mix (R4 R5 R6 R7 R8 R9)
    for (int it = 0; it < 600; it++) begin
      int s, k;
      logic [31:0] a, win;
      if (it % 8 == 0) begin
        logic [31:0] u;
        s = $urandom_range(0, 1);
        k = $urandom_range(0, 3);
        u = $urandom;
        win = (u & 32'h0000_1FFC) << 15;
        if ($urandom_range(0, 3) != 0) u = u & ~win;
        wreg(s[0], k, 1'b1, u);
        wreg(s[0], k, 1'b0, $urandom);
      end
      s = $urandom_range(0, 1);
      k = $urandom_range(0, 3);
      win = (m_up[s][k] & 32'h0000_1FFC) << 15;
      a = (m_up[s][k] & 32'hFFFE_0000) | ($urandom & (win | 32'h0001_FFFF));
      if ($urandom_range(0, 4) == 0) a = $urandom;
      access("R4 R5 R8 R9 random", a, s[0], 1'($urandom), 1'($urandom),
             ($urandom_range(0, 5) != 0), ($urandom_range(0, 5) != 0));
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule